// File: doc/BRIEF.md
# Lane Octet Substitution Unit

This block sits on one transmit lane of a serial converter link, after the transport packer and before the 8b/10b encoder. It watches the octet stream, keeps track of where frames and multiframes begin and end, and replaces some end-of-frame octets with control characters. The receiver uses these characters to keep checking frame and lane alignment while ordinary data is flowing.

An octet is replaced only when it is the last octet of its frame and its value equals the last octet of the frame just before it. When lane synchronization is enabled and the frame also closes a multiframe, a different control character is used. Substitution starts with a start-of-data pulse, which arrives once initial lane alignment has finished. Before that pulse, octets pass through untouched. Frame length and multiframe length are configuration inputs, each given as the count minus one. The output is one register stage behind the input.

Top module: `lane_octet_subst`

## Requirements
- R1: Every input appears at the output exactly one clock later. `out_valid_o` equals `in_valid_i` of the previous cycle, and `out_data_o` carries that cycle's `in_data_i` unless the octet is substituted.
- R2: From reset until the first `start_i` pulse, octets pass through unchanged and `out_ctrl_o` stays low.
- R3: Valid octets that are not the last octet of their frame pass through unchanged, with `out_ctrl_o` low.
- R4: A frame's last octet is compared with the last octet of the preceding frame. The first frame after `start_i` has no predecessor, so its last octet is never substituted. A last octet that does not match passes through unchanged.
- R5: If the last octet of a frame matches, it is sent as 0xFC with `out_ctrl_o` high. This applies when the frame does not close a multiframe, or when `lane_sync_en_i` is low.
- R6: If `lane_sync_en_i` is high and the frame closes a multiframe, a matching last octet is sent as 0x7C with `out_ctrl_o` high.
- R7: If `lane_sync_en_i` is low, the last octet of a multiframe follows the ordinary frame rule, so 0x7C is never produced.
- R8: The comparison always uses the original data value of the previous frame's last octet, never the control character that was sent in its place. A run of identical last octets is therefore substituted in every frame after the first.
- R9: `start_i` makes the octet in the same cycle the first octet of frame 0 of multiframe 0, and it clears the comparison history. This also holds when `start_i` arrives in the middle of a frame.
- R10: Octets per frame is `frame_len_m1_i`+1, from 1 to 16. Frames per multiframe is `mf_len_m1_i`+1, from 1 to 32. With one octet per frame, every octet is the last octet of its frame.
- R11: While `rst_ni` is low, `out_valid_o`, `out_ctrl_o` and `out_data_o` are all zero.
- R12: Cycles with `in_valid_i` low do not advance the frame or multiframe position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-of-data pulse; arms substitution and realigns the counters |
| lane_sync_en_i | input | 1 | Enables the separate multiframe-end character |
| frame_len_m1_i | input | 4 | Octets per frame minus one |
| mf_len_m1_i | input | 5 | Frames per multiframe minus one |
| in_valid_i | input | 1 | Input octet strobe |
| in_data_i | input | 8 | Input octet |
| out_valid_o | output | 1 | Output octet strobe |
| out_data_o | output | 8 | Output octet or control character code |
| out_ctrl_o | output | 1 | High when out_data_o is a control character |

## Verification
The hardest case to reach is a multiframe-end octet that matches while lane synchronization is on. It needs a frame position that is only visible by counting, plus a value repeat across frames. The stimulus reaches it by drawing octets from a two-value alphabet, so repeats are frequent, and by running short frame and multiframe lengths, including one-octet frames.

A restart in the middle of a frame and random gaps in the valid strobe exercise the realignment and the hold behaviour. A behavioural model counts positions independently of the design and is compared with the design on every clock.

// File: rtl/lane_subst_pkg.sv
package lane_subst_pkg;
  localparam logic [7:0] K_FRAME_END = 8'hFC;  // K28.7
  localparam logic [7:0] K_MF_END    = 8'h7C;  // K28.3

  typedef struct packed {
    logic last_oct;
    logic mf_end;
  } pos_t;
endpackage

// File: rtl/lane_frame_tracker.sv
module lane_frame_tracker
  import lane_subst_pkg::*;
#(
  parameter int FLEN_W = 4,
  parameter int MLEN_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [FLEN_W-1:0] frame_len_m1_i,
  input  logic [MLEN_W-1:0] mf_len_m1_i,
  output logic              armed_o,
  output pos_t              pos_o
);
  logic              armed_q;
  logic [FLEN_W-1:0] oct_q, oct_cur;
  logic [MLEN_W-1:0] frm_q, frm_cur;
  logic              adv;

  assign armed_o = armed_q | start_i;
  assign adv     = valid_i & armed_o;

  // start_i realigns the octet in its own cycle to position zero
  always_comb begin
    oct_cur = start_i ? '0 : oct_q;
    frm_cur = start_i ? '0 : frm_q;
    pos_o.last_oct = (oct_cur == frame_len_m1_i);
    pos_o.mf_end   = pos_o.last_oct && (frm_cur == mf_len_m1_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      oct_q   <= '0;
      frm_q   <= '0;
    end else begin
      if (start_i) armed_q <= 1'b1;
      if (adv) begin
        if (pos_o.last_oct) begin
          oct_q <= '0;
          frm_q <= pos_o.mf_end ? '0 : frm_cur + 1'b1;
        end else begin
          oct_q <= oct_cur + 1'b1;
          frm_q <= frm_cur;
        end
      end else if (start_i) begin
        oct_q <= '0;
        frm_q <= '0;
      end
    end
  end
endmodule

// File: rtl/lane_subst_core.sv
module lane_subst_core
  import lane_subst_pkg::*;
#(
  parameter int OCT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             take_i,
  input  pos_t             pos_i,
  input  logic             lane_sync_en_i,
  input  logic [OCT_W-1:0] data_i,
  output logic [OCT_W-1:0] data_o,
  output logic             ctrl_o
);
  logic [OCT_W-1:0] prev_q;
  logic             have_q, have_cur, match;

  assign have_cur = have_q & ~start_i;
  assign match    = take_i & pos_i.last_oct & have_cur & (data_i == prev_q);

  always_comb begin
    data_o = data_i;
    if (match) data_o = (pos_i.mf_end & lane_sync_en_i) ? OCT_W'(K_MF_END) : OCT_W'(K_FRAME_END);
  end
  assign ctrl_o = match;

  // history holds the original octet, never the substituted code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (take_i & pos_i.last_oct) begin
      prev_q <= data_i;
      have_q <= 1'b1;
    end else if (start_i) begin
      have_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_out_stage.sv
module lane_out_stage #(
  parameter int OCT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OCT_W-1:0] data_i,
  input  logic             ctrl_i,
  output logic             valid_o,
  output logic [OCT_W-1:0] data_o,
  output logic             ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ctrl_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      data_o  <= data_i;
      ctrl_o  <= ctrl_i & valid_i;
    end
  end
endmodule

// File: rtl/lane_octet_subst.sv
module lane_octet_subst
  import lane_subst_pkg::*;
#(
  parameter int FLEN_W = 4,
  parameter int MLEN_W = 5,
  parameter int OCT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              lane_sync_en_i,
  input  logic [FLEN_W-1:0] frame_len_m1_i,
  input  logic [MLEN_W-1:0] mf_len_m1_i,
  input  logic              in_valid_i,
  input  logic [OCT_W-1:0]  in_data_i,
  output logic              out_valid_o,
  output logic [OCT_W-1:0]  out_data_o,
  output logic              out_ctrl_o
);
  logic             armed;
  pos_t             pos;
  logic [OCT_W-1:0] sub_data;
  logic             sub_ctrl;

  lane_frame_tracker #(.FLEN_W(FLEN_W), .MLEN_W(MLEN_W)) u_track (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .valid_i        (in_valid_i),
    .frame_len_m1_i (frame_len_m1_i),
    .mf_len_m1_i    (mf_len_m1_i),
    .armed_o        (armed),
    .pos_o          (pos)
  );

  lane_subst_core #(.OCT_W(OCT_W)) u_core (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .take_i         (in_valid_i & armed),
    .pos_i          (pos),
    .lane_sync_en_i (lane_sync_en_i),
    .data_i         (in_data_i),
    .data_o         (sub_data),
    .ctrl_o         (sub_ctrl)
  );

  lane_out_stage #(.OCT_W(OCT_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .data_i  (sub_data),
    .ctrl_i  (sub_ctrl),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .ctrl_o  (out_ctrl_o)
  );
endmodule

// File: rtl/lane_octet_subst_chk.sv
module lane_octet_subst_chk
  import lane_subst_pkg::*;
#(
  parameter int FLEN_W = 4,
  parameter int MLEN_W = 5,
  parameter int OCT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              lane_sync_en_i,
  input logic [FLEN_W-1:0] frame_len_m1_i,
  input logic [MLEN_W-1:0] mf_len_m1_i,
  input logic              in_valid_i,
  input logic [OCT_W-1:0]  in_data_i,
  input logic              out_valid_o,
  input logic [OCT_W-1:0]  out_data_o,
  input logic              out_ctrl_o
);
  logic seen_start_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_start_q <= 1'b0;
    else if (start_i) seen_start_q <= 1'b1;
  end

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> out_valid_o == $past(in_valid_i));

  p_passthru_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (out_ctrl_o || out_data_o == $past(in_data_i)));

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_start_q && !start_i) |=> !out_ctrl_o);

  p_ctrl_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ctrl_o |-> (out_valid_o &&
      (out_data_o == OCT_W'(K_FRAME_END) || out_data_o == OCT_W'(K_MF_END))));

  p_no_mf_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_sync_en_i |=> (!out_ctrl_o || out_data_o == OCT_W'(K_FRAME_END)));
endmodule

bind lane_octet_subst lane_octet_subst_chk #(
  .FLEN_W(FLEN_W), .MLEN_W(MLEN_W), .OCT_W(OCT_W)
) u_chk (.*);

// File: tb/lane_octet_subst_bench.sv
`timescale 1ns/1ps
module lane_octet_subst_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       lane_sync_en_i = 1'b0;
  logic [3:0] frame_len_m1_i = 4'd0;
  logic [4:0] mf_len_m1_i = 5'd0;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_data_i = 8'd0;
  logic       out_valid_o;
  logic [7:0] out_data_o;
  logic       out_ctrl_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #2.5 clk_i = ~clk_i;  // 200 MHz

  lane_octet_subst u_lane_octet_subst (.*);

  // behavioural reference
  bit         exp_v, exp_c;
  logic [7:0] exp_d;
  string      exp_tag = "R11";
  bit         armed, have_prev;
  int         oct_pos, frm_pos;
  logic [7:0] prev_last;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      exp_v = 0; exp_c = 0; exp_d = 0; exp_tag = "R11";
      armed = 0; have_prev = 0; oct_pos = 0; frm_pos = 0; prev_last = 0;
    end else begin
      exp_v = in_valid_i; exp_d = in_data_i; exp_c = 0;
      exp_tag = (armed || start_i) ? "R3" : "R2";
      if (!in_valid_i) exp_tag = "R12";
      if (start_i) begin
        armed = 1; have_prev = 0; oct_pos = 0; frm_pos = 0;
        exp_tag = "R9";
      end
      if (in_valid_i && armed) begin
        if (oct_pos == int'(frame_len_m1_i)) begin
          bit mfe;
          mfe = (frm_pos == int'(mf_len_m1_i));
          exp_tag = (frame_len_m1_i == 0) ? "R10" : "R4";
          if (have_prev && in_data_i == prev_last) begin
            exp_c = 1;
            exp_d = (mfe && lane_sync_en_i) ? 8'h7C : 8'hFC;
            exp_tag = (mfe && lane_sync_en_i) ? "R6" : (mfe ? "R7" : "R8");
          end
          prev_last = in_data_i; have_prev = 1; oct_pos = 0;
          frm_pos = mfe ? 0 : frm_pos + 1;
        end else begin
          oct_pos++;
        end
      end
    end
  end

  task automatic compare();
    vectors++;
    if (out_valid_o !== exp_v || out_data_o !== exp_d || out_ctrl_o !== exp_c) begin
      errors++;
      $display("FAIL %s: got v=%0b d=%02h c=%0b expected v=%0b d=%02h c=%0b",
               exp_tag, out_valid_o, out_data_o, out_ctrl_o, exp_v, exp_d, exp_c);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] d, input bit s);
    @(negedge clk_i);
    compare();
    in_valid_i = v; in_data_i = d; start_i = s;
  endtask

  function automatic logic [7:0] pick(input int mode);
    if (mode == 0) return $urandom_range(0, 1) ? 8'h11 : 8'h22;
    if (mode == 1) return 8'h55;
    if (mode == 2) return $urandom_range(0, 3) == 0 ? 8'hFC : 8'h7C;
    return 8'($urandom);
  endfunction

  task automatic run(input int n, input int mode, input int gap_pct);
    for (int i = 0; i < n; i++)
      step($urandom_range(0, 99) >= gap_pct, pick(mode), 1'b0);
  endtask

  task automatic restart(input bit sync, input int f, input int k);
    step(1'b0, 8'h00, 1'b0);
    lane_sync_en_i = sync; frame_len_m1_i = 4'(f); mf_len_m1_i = 5'(k);
    step(1'b1, pick(0), 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R11: outputs held at zero in reset
    vectors++;
    if (out_valid_o !== 0 || out_data_o !== 0 || out_ctrl_o !== 0) begin
      errors++;
      $display("FAIL R11: got v=%0b d=%02h c=%0b expected 0 00 0",
               out_valid_o, out_data_o, out_ctrl_o);
    end
    rst_ni = 1'b1;
    lane_sync_en_i = 1; frame_len_m1_i = 3; mf_len_m1_i = 1;
    run(40, 1, 0);        // R2: repeats before start, no substitution
    restart(1, 3, 1);     // R6 with sync on
    run(300, 0, 20);
    run(60, 1, 0);        // R8: constant run
    restart(0, 3, 1);     // R7: sync off
    run(300, 0, 20);
    restart(1, 0, 0);     // R10: one-octet frames, every frame closes mf
    run(200, 0, 30);
    restart(1, 0, 2);
    run(200, 2, 10);
    restart(1, 15, 31);   // maximum lengths
    run(1500, 0, 5);
    run(20, 3, 10);
    restart(1, 2, 3);
    run(5, 0, 0);
    step(1'b1, 8'h11, 1'b1); // R9: mid-frame restart
    run(300, 0, 25);
    for (int r = 0; r < 30; r++) begin
      restart($urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 31));
      run(200, $urandom_range(0, 3), $urandom_range(0, 40));
    end
    step(1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule